// File: doc/BRIEF.md
# Four-Channel DMA Register Engine

This block is a four-channel DMA engine that a processor programs over an 8-bit I/O write bus. Each channel holds a 16-bit transfer address, a 16-bit count, an 8-bit page and a mode. All 16-bit values are loaded through a single byte-wide port. A shared byte-pointer toggle decides which half each write lands in, and software can force that toggle back to the low half. A peripheral raises its request line. The engine grants one transfer at a time and drives a 24-bit memory address together with a write or read strobe. It then steps the channel's address and count.

The parameter `WORD_MODE` chooses between two variants. The byte variant addresses bytes and uses register offsets one apart. The word variant uses register offsets two apart, treats the programmed address as a 16-bit word index, and counts in words. A system with eight channels is built from one instance of each variant. A channel can also be set to cascade, where it only passes its request back as an acknowledge so that a downstream controller can own the bus.

Top module: `dma4_port_engine`

## Requirements
- R1: While reset is held and after it is released, every channel is masked, the byte pointer selects the low half, the tc_flag bits are 0, and dack, tc, mem_wr and mem_rd are all 0.
- R2: Address register offsets are 2c and count register offsets are 2c+1, scaled by the stride: 1 in byte mode, 2 in word mode. The low byte of a 16-bit value is written first and the high byte second. Each such write toggles the byte pointer, and any write to offset 12 (times the stride) returns the pointer to the low half.
- R3: A write to offset 11 (times the stride) sets the mode of the channel named in data bits 1:0. Bits 3:2 give the direction: 01 is memory write and raises mem_wr, 10 is memory read and raises mem_rd. Bits 7:6 give the type: 01 is single, 11 is cascade, and any other value is idle.
- R4: A write to offset 10 (times the stride) picks the channel from data bits 1:0. Bit 2 set masks that channel and bit 2 clear unmasks it. A masked channel ignores its request.
- R5: When a single-mode, unmasked channel sees its request while the engine is idle, dack for that channel is high for exactly one cycle, starting the cycle after the request is sampled. The address and the strobe appear in the same cycle. Another transfer on that channel needs the request to go low first.
- R6: Each transfer increments the channel address by one and decrements its count by one.
- R7: A count programmed as N-1 gives N transfers. The last transfer raises tc for that channel alongside its dack, masks the channel, and sets its tc_flag bit. The flag is cleared by the next mode write to that channel.
- R8: In byte mode mem_addr is {page, address}. The address wraps from 0xFFFF to 0x0000 and never carries into the page.
- R9: In word mode mem_addr is {page[7:1], address, 0}, so a transfer wraps inside a 128 KiB window.
- R10: A cascade channel that is unmasked drives dack equal to its request in the same cycle. It produces no strobe and its address does not change.
- R11: When several channels become eligible in the same cycle, the lowest-numbered channel is served first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | I/O register write strobe |
| io_addr | input | IO_AW | Register offset |
| io_wdata | input | 8 | Write data byte |
| pg_wr | input | 1 | Page register write strobe |
| pg_sel | input | $clog2(NCH) | Channel whose page is written |
| dreq | input | NCH | Per-channel transfer request |
| dack | output | NCH | Per-channel acknowledge |
| tc | output | NCH | Terminal count, high with the last acknowledge |
| tc_flag | output | NCH | Sticky terminal-count status |
| mem_addr | output | 24 | Memory address of the current transfer |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |

## Verification
Wrong state in this block becomes visible on the ports within one cycle of the next granted request. A stale or misrouted byte pointer shows as swapped address bytes on mem_addr. An address or count register that steps wrongly shows as a wrong address on the second transfer, or as tc arriving early or late. A lost mask bit or arming bit shows as an extra acknowledge. Page and word-mode faults show in the upper bits of mem_addr, and are checked exactly at the wrap point.

// File: rtl/dma4_pkg.sv
// Shared encodings for the DMA register engine.
// Assumes the mode byte layout {type[7:6], spare[5:4], dir[3:2], ch[1:0]}.
package dma4_pkg;

    typedef enum logic [1:0] {
        XM_IDLE    = 2'b00,
        XM_SINGLE  = 2'b01,
        XM_RSVD    = 2'b10,
        XM_CASCADE = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        DIR_NONE  = 2'b00,
        DIR_MEMWR = 2'b01,
        DIR_MEMRD = 2'b10,
        DIR_BAD   = 2'b11
    } xfer_dir_e;

    typedef struct packed {
        xfer_mode_e xm;
        logic [1:0] spare;
        xfer_dir_e  dir;
        logic [1:0] ch;
    } mode_byte_t;

    localparam int OFF_MASK = 10;
    localparam int OFF_MODE = 11;
    localparam int OFF_CLR  = 12;

endpackage

// File: rtl/dma4_port_decode.sv
// Decodes I/O writes into per-channel register strobes and owns the
// byte-pointer toggle. Assumes io_addr is already local to this engine;
// in word mode odd offsets are ignored and the offset is halved.
module dma4_port_decode #(
    parameter int NCH       = 4,
    parameter bit WORD_MODE = 1'b0,
    parameter int IO_AW     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_wr,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [7:0]       io_wdata,
    output logic             hi_byte,
    output logic [NCH-1:0]   adr_we,
    output logic [NCH-1:0]   cnt_we,
    output logic [NCH-1:0]   mode_we,
    output logic [NCH-1:0]   mask_we
);
    import dma4_pkg::*;

    localparam int CH_W = $clog2(NCH);

    logic [IO_AW-1:0] idx;
    logic             aligned;
    logic             hit;
    logic             clr_hit;

    // Map the bus offset to a register index according to the stride.
    generate
        if (WORD_MODE) begin : g_word
            assign idx     = io_addr >> 1;
            assign aligned = ~io_addr[0];
        end else begin : g_byte
            assign idx     = io_addr;
            assign aligned = 1'b1;
        end
    endgenerate

    assign hit     = io_wr & aligned;
    assign clr_hit = hit && (idx == IO_AW'(OFF_CLR));

    // Per-channel strobes for the address, count, mode and mask writes.
    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            localparam logic [IO_AW-1:0] A_IDX = IO_AW'(2 * c);
            localparam logic [IO_AW-1:0] C_IDX = IO_AW'(2 * c + 1);
            assign adr_we[c]  = hit && (idx == A_IDX);
            assign cnt_we[c]  = hit && (idx == C_IDX);
            assign mode_we[c] = hit && (idx == IO_AW'(OFF_MODE)) &&
                                (io_wdata[CH_W-1:0] == CH_W'(c));
            assign mask_we[c] = hit && (idx == IO_AW'(OFF_MASK)) &&
                                (io_wdata[CH_W-1:0] == CH_W'(c));
        end
    endgenerate

    // Byte-pointer toggle: cleared by the clear register, flipped by 16-bit writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_byte <= 1'b0;
        else if (clr_hit)
            hi_byte <= 1'b0;
        else if ((|adr_we) || (|cnt_we))
            hi_byte <= ~hi_byte;
    end

endmodule

// File: rtl/dma4_chan.sv
// One DMA channel: address, count, page, mode, mask, arming and status.
// Assumes at most one of the write strobes and take is active per cycle
// in normal use; take has no effect unless the channel reported ready.
module dma4_chan #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adr_we,
    input  logic          cnt_we,
    input  logic          mode_we,
    input  logic          mask_we,
    input  logic          page_we,
    input  logic          hi_byte,
    input  logic [7:0]    wdata,
    input  logic          req,
    input  logic          take,
    output logic          ready,
    output logic          casc_ack,
    output logic [15:0]   cur_addr,
    output logic [PW-1:0] page,
    output dma4_pkg::xfer_dir_e dir,
    output logic          last,
    output logic          tc_flag
);
    import dma4_pkg::*;

    logic [15:0] cur_cnt;
    xfer_mode_e  xm;
    logic        masked;
    logic        armed;
    mode_byte_t  mb;

    assign mb   = mode_byte_t'(wdata);
    assign last = (cur_cnt == 16'h0000);

    // Address: byte-wise load, otherwise step by one per transfer (wraps).
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_addr <= '0;
        else if (adr_we) begin
            if (hi_byte) cur_addr[15:8] <= wdata;
            else         cur_addr[7:0]  <= wdata;
        end else if (take)
            cur_addr <= cur_addr + 16'd1;
    end

    // Count: byte-wise load, otherwise step down by one per transfer.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_cnt <= '0;
        else if (cnt_we) begin
            if (hi_byte) cur_cnt[15:8] <= wdata;
            else         cur_cnt[7:0]  <= wdata;
        end else if (take)
            cur_cnt <= cur_cnt - 16'd1;
    end

    // Page register holding the upper address bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            page <= '0;
        else if (page_we)
            page <= wdata[PW-1:0];
    end

    // Mode fields latched from a mode write aimed at this channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xm  <= XM_IDLE;
            dir <= DIR_NONE;
        end else if (mode_we) begin
            xm  <= mb.xm;
            dir <= mb.dir;
        end
    end

    // Mask: set at reset, written by software, set again on terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            masked <= 1'b1;
        else if (mask_we)
            masked <= wdata[2];
        else if (take && last)
            masked <= 1'b1;
    end

    // Arming: a transfer disarms the channel until its request drops.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (take)
            armed <= 1'b0;
        else if (!req)
            armed <= 1'b1;
    end

    // Sticky terminal-count status, cleared by a mode write to this channel.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tc_flag <= 1'b0;
        else if (mode_we)
            tc_flag <= 1'b0;
        else if (take && last)
            tc_flag <= 1'b1;
    end

    assign ready    = (xm == XM_SINGLE) && !masked && armed && req;
    assign casc_ack = (xm == XM_CASCADE) && !masked && req;

endmodule

// File: rtl/dma4_prio.sv
// Fixed-priority selector: the lowest-numbered ready channel wins.
// Assumes nothing about the input; the output is one-hot or zero.
module dma4_prio #(
    parameter int N = 4
) (
    input  logic [N-1:0] ready,
    output logic [N-1:0] grant
);
    // Scan upward and keep only the first set bit.
    always_comb begin
        logic found;
        found = 1'b0;
        grant = '0;
        for (int i = 0; i < N; i++) begin
            if (ready[i] && !found) begin
                grant[i] = 1'b1;
                found    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma4_port_engine.sv
// Top of the DMA register engine: port decode, per-channel state,
// priority selection and registered transfer outputs. Assumes
// NCH <= 4 so that the channel registers sit below the mask offset.
module dma4_port_engine #(
    parameter int NCH       = 4,
    parameter bit WORD_MODE = 1'b0,
    parameter int IO_AW     = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    io_wr,
    input  logic [IO_AW-1:0]        io_addr,
    input  logic [7:0]              io_wdata,
    input  logic                    pg_wr,
    input  logic [$clog2(NCH)-1:0]  pg_sel,
    input  logic [NCH-1:0]          dreq,
    output logic [NCH-1:0]          dack,
    output logic [NCH-1:0]          tc,
    output logic [NCH-1:0]          tc_flag,
    output logic [23:0]             mem_addr,
    output logic                    mem_wr,
    output logic                    mem_rd
);
    import dma4_pkg::*;

    localparam int PW   = 8;
    localparam int CH_W = $clog2(NCH);

    logic             hi_byte;
    logic [NCH-1:0]   adr_we, cnt_we, mode_we, mask_we, page_we;
    logic [NCH-1:0]   ready, casc_vec, last_vec, grant;
    logic [15:0]      addr_vec [NCH];
    logic [PW-1:0]    page_vec [NCH];
    xfer_dir_e        dir_vec  [NCH];

    logic [15:0]      sel_addr;
    logic [PW-1:0]    sel_page;
    xfer_dir_e        sel_dir;
    logic [23:0]      sel_phys;

    logic [NCH-1:0]   xfer_ack;
    logic [NCH-1:0]   tc_q;
    logic [23:0]      addr_q;
    logic             wr_q, rd_q;

    dma4_port_decode #(
        .NCH(NCH), .WORD_MODE(WORD_MODE), .IO_AW(IO_AW)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr),
        .io_wdata(io_wdata), .hi_byte(hi_byte), .adr_we(adr_we),
        .cnt_we(cnt_we), .mode_we(mode_we), .mask_we(mask_we)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chan
            assign page_we[c] = pg_wr && (pg_sel == CH_W'(c));
            dma4_chan #(.PW(PW)) u_chan (
                .clk(clk), .rst_n(rst_n),
                .adr_we(adr_we[c]), .cnt_we(cnt_we[c]),
                .mode_we(mode_we[c]), .mask_we(mask_we[c]),
                .page_we(page_we[c]), .hi_byte(hi_byte),
                .wdata(io_wdata), .req(dreq[c]), .take(grant[c]),
                .ready(ready[c]), .casc_ack(casc_vec[c]),
                .cur_addr(addr_vec[c]), .page(page_vec[c]),
                .dir(dir_vec[c]), .last(last_vec[c]),
                .tc_flag(tc_flag[c])
            );
        end
    endgenerate

    dma4_prio #(.N(NCH)) u_prio (.ready(ready), .grant(grant));

    // Route the granted channel's address, page and direction.
    always_comb begin
        sel_addr = '0;
        sel_page = '0;
        sel_dir  = DIR_NONE;
        for (int c = 0; c < NCH; c++) begin
            if (grant[c]) begin
                sel_addr = addr_vec[c];
                sel_page = page_vec[c];
                sel_dir  = dir_vec[c];
            end
        end
    end

    // Build the physical address for the selected variant.
    generate
        if (WORD_MODE) begin : g_word_addr
            assign sel_phys = {sel_page[PW-1:1], sel_addr, 1'b0};
        end else begin : g_byte_addr
            assign sel_phys = {sel_page, sel_addr};
        end
    endgenerate

    // Register the transfer cycle: acknowledge, terminal count, address, strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_ack <= '0;
            tc_q     <= '0;
            addr_q   <= '0;
            wr_q     <= 1'b0;
            rd_q     <= 1'b0;
        end else begin
            xfer_ack <= grant;
            tc_q     <= grant & last_vec;
            addr_q   <= sel_phys;
            wr_q     <= (|grant) && (sel_dir == DIR_MEMWR);
            rd_q     <= (|grant) && (sel_dir == DIR_MEMRD);
        end
    end

    assign dack     = xfer_ack | casc_vec;
    assign tc       = tc_q;
    assign mem_addr = addr_q;
    assign mem_wr   = wr_q;
    assign mem_rd   = rd_q;

endmodule

// File: rtl/dma4_port_engine_chk.sv
// Protocol checker for dma4_port_engine, bound to every instance.
// Assumes xfer_ack is the registered single-mode acknowledge vector.
module dma4_port_engine_chk #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic [NCH-1:0] dreq,
    input logic [NCH-1:0] xfer_ack,
    input logic [NCH-1:0] tc,
    input logic           mem_wr,
    input logic           mem_rd
);
    // R1: the cycle after a reset edge has no activity.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (tc == '0 && xfer_ack == '0 && !mem_wr && !mem_rd));

    // R3: a transfer never strobes both directions.
    assert_dir_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr && mem_rd));

    // R5: a strobe only appears with a transfer acknowledge.
    assert_strobe_with_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr || mem_rd) |-> (xfer_ack != '0));

    // R5: a single-mode acknowledge lasts one cycle.
    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ack != '0) |=> ((xfer_ack & $past(xfer_ack)) == '0));

    // R5: an acknowledge follows a request sampled on the previous edge.
    assert_req_before_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_ack != '0) |-> ((xfer_ack & ~$past(dreq)) == '0));

    // R7: terminal count only comes with that channel's acknowledge.
    assert_tc_in_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tc & ~xfer_ack) == '0);

    // R11: at most one channel is served per cycle.
    assert_one_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(xfer_ack));

endmodule

bind dma4_port_engine dma4_port_engine_chk #(.NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .dreq(dreq), .xfer_ack(xfer_ack),
    .tc(tc), .mem_wr(mem_wr), .mem_rd(mem_rd)
);

// File: tb/tb_dma4_port_engine.sv
// Directed bench: a byte-mode instance (dut) and a word-mode instance (dut_w).
module tb_dma4_port_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       io_wr_b = 1'b0, io_wr_w = 1'b0;
    logic [4:0] io_addr = '0;
    logic [7:0] io_wdata = '0;
    logic       pg_wr_b = 1'b0, pg_wr_w = 1'b0;
    logic [1:0] pg_sel = '0;
    logic [3:0] dreq_b = '0, dreq_w = '0;
    logic [3:0] dack_b, dack_w, tc_b, tc_w, flag_b, flag_w;
    logic [23:0] addr_b, addr_w;
    logic       wr_b, rd_b, wr_w, rd_w;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dma4_port_engine #(.NCH(4), .WORD_MODE(1'b0), .IO_AW(5)) dut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr_b), .io_addr(io_addr),
        .io_wdata(io_wdata), .pg_wr(pg_wr_b), .pg_sel(pg_sel),
        .dreq(dreq_b), .dack(dack_b), .tc(tc_b), .tc_flag(flag_b),
        .mem_addr(addr_b), .mem_wr(wr_b), .mem_rd(rd_b)
    );

    dma4_port_engine #(.NCH(4), .WORD_MODE(1'b1), .IO_AW(5)) dut_w (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr_w), .io_addr(io_addr),
        .io_wdata(io_wdata), .pg_wr(pg_wr_w), .pg_sel(pg_sel),
        .dreq(dreq_w), .dack(dack_w), .tc(tc_w), .tc_flag(flag_w),
        .mem_addr(addr_w), .mem_wr(wr_w), .mem_rd(rd_w)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] ea(input bit w, input logic [7:0] pg, input logic [15:0] a);
        return w ? {pg[7:1], a, 1'b0} : {pg, a};
    endfunction

    task automatic wr(input bit w, input int off, input logic [7:0] d);
        @(negedge clk);
        io_addr  = w ? 5'(off * 2) : 5'(off);
        io_wdata = d;
        io_wr_b  = !w;
        io_wr_w  = w;
        @(negedge clk);
        io_wr_b = 1'b0;
        io_wr_w = 1'b0;
    endtask

    task automatic pg(input bit w, input int ch, input logic [7:0] d);
        @(negedge clk);
        pg_sel   = 2'(ch);
        io_wdata = d;
        pg_wr_b  = !w;
        pg_wr_w  = w;
        @(negedge clk);
        pg_wr_b = 1'b0;
        pg_wr_w = 1'b0;
    endtask

    task automatic setup(input bit w, input int ch, input logic [15:0] a,
                         input logic [15:0] n, input logic [7:0] p, input logic [7:0] m);
        wr(w, 12, 8'h00);
        wr(w, 2 * ch, a[7:0]);
        wr(w, 2 * ch, a[15:8]);
        wr(w, 2 * ch + 1, n[7:0]);
        wr(w, 2 * ch + 1, n[15:8]);
        pg(w, ch, p);
        wr(w, 11, m);
        wr(w, 10, 8'(ch));
    endtask

    // One request pulse; checks acknowledge, address, strobes and tc.
    task automatic xfer(input bit w, input int ch, input logic [23:0] exp_a,
                        input bit is_wr, input bit exp_tc, input string tag);
        @(negedge clk);
        if (w) dreq_w[ch] = 1'b1; else dreq_b[ch] = 1'b1;
        @(negedge clk);
        chk({tag, " dack"}, w ? dack_w : dack_b, 32'(1 << ch));
        chk({tag, " addr"}, w ? addr_w : addr_b, exp_a);
        chk({tag, " wr"},   w ? wr_w : wr_b, is_wr);
        chk({tag, " rd"},   w ? rd_w : rd_b, !is_wr);
        chk({tag, " tc"},   w ? tc_w : tc_b, exp_tc ? 32'(1 << ch) : 32'd0);
        if (w) dreq_w[ch] = 1'b0; else dreq_b[ch] = 1'b0;
        @(negedge clk);
        chk({tag, " dack drop"}, w ? dack_w : dack_b, 32'd0);
    endtask

    task automatic no_xfer(input int ch, input string tag);
        @(negedge clk);
        dreq_b[ch] = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk({tag, " no dack"}, dack_b, 32'd0);
        end
        dreq_b[ch] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 dack", {dack_w, dack_b}, 32'd0);
        chk("R1 tc", {tc_w, tc_b}, 32'd0);
        chk("R1 tc_flag", {flag_w, flag_b}, 32'd0);
        chk("R1 strobes", {wr_b, rd_b, wr_w, rd_w}, 32'd0);
        // Mode written but no unmask: the reset mask must hold (R1).
        wr(0, 11, 8'h44);
        no_xfer(0, "R1 reset mask");
    endtask

    task automatic t_program;
        setup(0, 1, 16'h1234, 16'h0002, 8'h56, 8'h45);
        xfer(0, 1, 24'h561234, 1'b1, 1'b0, "R2 R3 first");
        xfer(0, 1, 24'h561235, 1'b1, 1'b0, "R6 second");
        xfer(0, 1, 24'h561236, 1'b1, 1'b1, "R7 last");
        chk("R7 flag set", flag_b, 32'h2);
        no_xfer(1, "R7 self mask");
        wr(0, 11, 8'h45);
        chk("R7 flag cleared", flag_b, 32'h0);
    endtask

    task automatic t_hold;
        int acks = 0;
        setup(0, 0, 16'h0100, 16'h0005, 8'h01, 8'h48);
        @(negedge clk);
        dreq_b[0] = 1'b1;
        repeat (4) begin
            @(negedge clk);
            if (dack_b[0]) acks++;
        end
        chk("R5 one ack per request", acks, 1);
        dreq_b[0] = 1'b0;
        xfer(0, 0, 24'h010101, 1'b0, 1'b0, "R5 R6 rearm");
    endtask

    task automatic t_ffclear;
        wr(0, 12, 8'h00);
        wr(0, 6, 8'hAA);
        wr(0, 12, 8'h00);
        wr(0, 6, 8'h11);
        wr(0, 6, 8'h22);
        wr(0, 7, 8'h00);
        wr(0, 7, 8'h00);
        pg(0, 3, 8'h09);
        wr(0, 11, 8'h47);
        wr(0, 10, 8'h03);
        xfer(0, 3, 24'h092211, 1'b1, 1'b1, "R2 pointer clear");
    endtask

    task automatic t_mask;
        setup(0, 3, 16'h4000, 16'h0009, 8'h02, 8'h47);
        wr(0, 10, 8'h07);
        no_xfer(3, "R4 masked");
        wr(0, 10, 8'h03);
        xfer(0, 3, 24'h024000, 1'b1, 1'b0, "R4 unmasked");
    endtask

    task automatic t_priority;
        @(negedge clk);
        dreq_b[0] = 1'b1;
        dreq_b[3] = 1'b1;
        @(negedge clk);
        chk("R11 lowest first", dack_b, 32'h1);
        dreq_b[0] = 1'b0;
        @(negedge clk);
        chk("R11 next served", dack_b, 32'h8);
        chk("R11 next addr", addr_b, 24'h024001);
        dreq_b[3] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_wrap;
        setup(0, 2, 16'hFFFF, 16'h0001, 8'h07, 8'h4A);
        xfer(0, 2, 24'h07FFFF, 1'b0, 1'b0, "R8 top");
        xfer(0, 2, 24'h070000, 1'b0, 1'b1, "R8 wrap");
    endtask

    task automatic t_cascade;
        wr(0, 11, 8'hC2);
        wr(0, 10, 8'h02);
        @(negedge clk);
        dreq_b[2] = 1'b1;
        #1;
        chk("R10 follow high", dack_b, 32'h4);
        @(negedge clk);
        chk("R10 no strobe", {wr_b, rd_b}, 32'd0);
        chk("R10 still acked", dack_b, 32'h4);
        dreq_b[2] = 1'b0;
        #1;
        chk("R10 follow low", dack_b, 32'h0);
        // Back to single mode: the address must be untouched by cascade (R10).
        wr(0, 11, 8'h4A);
        wr(0, 12, 8'h00);
        wr(0, 5, 8'h00);
        wr(0, 5, 8'h00);
        wr(0, 10, 8'h02);
        xfer(0, 2, 24'h070001, 1'b0, 1'b1, "R10 addr kept");
    endtask

    task automatic t_word;
        setup(1, 1, 16'h1234, 16'h0001, 8'h04, 8'h45);
        xfer(1, 1, ea(1, 8'h04, 16'h1234), 1'b1, 1'b0, "R9 first");
        xfer(1, 1, ea(1, 8'h04, 16'h1235), 1'b1, 1'b1, "R9 step");
        setup(1, 1, 16'hFFFF, 16'h0001, 8'h04, 8'h49);
        xfer(1, 1, 24'h05FFFE, 1'b0, 1'b0, "R9 top");
        xfer(1, 1, 24'h040000, 1'b0, 1'b1, "R9 wrap");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_hold();
        t_ffclear();
        t_mask();
        t_priority();
        t_wrap();
        t_cascade();
        t_word();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule